// File: doc/BRIEF.md
# Windowed Interrupt Routing Register File

This block holds the routing table of an interrupt router. It is reached through a pair of bus offsets. Offset 0x00 holds an 8-bit select register. Offset 0x10 is a data window that reads or writes whichever 32-bit register the select value names. The select space holds an identification register, a read-only version register, and one 64-bit routing entry per interrupt pin. Each entry is split into two 32-bit halves. An even select value names the low half and an odd select value names the high half.

The fields of every entry are driven out continuously, so the delivery logic can use them. The field layout is:

| Field | Bits |
|---|---|
| vector | [7:0] |
| delivery mode | [10:8] |
| destination mode | [11] |
| delivery status | [12] |
| polarity | [13] |
| remote in-service flag | [14] |
| trigger mode (1 = level) | [15] |
| mask | [16] |
| destination | [63:56] |

When a window write changes an entry's mask bit, the block gives a one-cycle notification carrying the pin index and the new mask value. The delivery logic raises the remote in-service flag through a per-pin set input. A write to the low half of an entry clears that flag.

Top module: `irq_route_regs`

## Requirements
- R1: A write to offset 0x00 stores bits 7:0 of the write data as the select value. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R2: With select 0x01, a window read returns (NPINS-1) in bits 23:16 and VERSION in bits 7:0, with all other bits zero. Window writes with select 0x01 change nothing.
- R3: With select 0x00 or 0x02, a window read returns the 4-bit ID in bits 27:24 and zeros elsewhere. A window write with select 0x00 loads the ID from data bits 27:24. A window write with select 0x02 is ignored.
- R4: For select values of 0x10 and above, the entry index is (select-0x10)>>1. An odd select value reads or writes entry bits 63:32 and an even select value reads or writes bits 31:0. The field outputs follow the stored entry, at the bit positions given in the layout table above.
- R5: A window read whose entry index is NPINS or more returns 0xFFFFFFFF. This also applies to select values 0x03 to 0x0F. A window write to any such index changes no entry and gives no notification.
- R6: A window write to the low half of an entry clears its remote in-service flag (bit 14), whatever the data holds. A pulse on set_inservice[i] sets the flag of entry i. A write to the high half leaves the flag as it was.
- R7: Reset sets the mask bit of every entry and clears every other entry bit. Reset also clears the select value, the ID and the read data.
- R8: When a window write changes an entry's mask bit, mask_evt is high for exactly one cycle after the write edge, with mask_evt_pin set to the entry index and mask_evt_val set to the new mask value. A write that leaves the mask unchanged gives no pulse.
- R9: A read of any offset other than 0x00 and 0x10 returns zero. A write to any such offset changes nothing.
- R10: bus_rdata is loaded at the clock edge where bus_rd is high, and it holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Offset: 0x00 select, 0x10 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| set_inservice | input | NPINS | Per-pin set of the remote in-service flag |
| route_vector | output | 8*NPINS | Vector of each entry, pin i at [8i+7:8i] |
| route_dlv_mode | output | 3*NPINS | Delivery mode of each entry |
| route_dest_mode | output | NPINS | Destination mode of each entry |
| route_polarity | output | NPINS | Polarity of each entry |
| route_inservice | output | NPINS | Remote in-service flag of each entry |
| route_trigger | output | NPINS | Trigger mode of each entry (1 = level) |
| route_mask | output | NPINS | Mask bit of each entry |
| route_dest | output | 8*NPINS | Destination of each entry |
| mask_evt | output | 1 | One-cycle pulse on a mask change |
| mask_evt_pin | output | $clog2(NPINS) | Entry index of the mask change |
| mask_evt_val | output | 1 | New mask value |

## Verification
Three kinds of result are timed differently.

- **Read data** is valid one edge after a read. Each read task raises bus_rd at a falling edge and samples bus_rdata at the next falling edge.
- **Field outputs and the select/ID state** change at the same edge that accepts the write. The checks read them at the falling edge that follows.
- **Mask notification** is checked at that same falling edge, and again one cycle later to confirm that it has dropped.

An in-service set pulse is given for one cycle. It is confirmed by a window read that starts at the next falling edge.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NPINS-1:0]      set_inservice,
  output logic [8*NPINS-1:0]    route_vector,
  output logic [3*NPINS-1:0]    route_dlv_mode,
  output logic [NPINS-1:0]      route_dest_mode,
  output logic [NPINS-1:0]      route_polarity,
  output logic [NPINS-1:0]      route_inservice,
  output logic [NPINS-1:0]      route_trigger,
  output logic [NPINS-1:0]      route_mask,
  output logic [8*NPINS-1:0]    route_dest,
  output logic                  mask_evt,
  output logic [IDXW-1:0]       mask_evt_pin,
  output logic                  mask_evt_val
);

  localparam logic [7:0] NP8 = 8'(NPINS);
  localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;

  logic [63:0] ent [NPINS];
  logic [7:0]  sel;
  logic [3:0]  id;
  logic [7:0]  ofs;
  logic        in_tab;
  logic [IDXW-1:0] idx;
  logic [63:0] cur, nxt;
  logic [31:0] rd_mux;

  wire sel_wr = bus_wr && bus_addr == 8'h00;
  wire win_wr = bus_wr && bus_addr == 8'h10;

  assign ofs    = sel - 8'h10;
  assign in_tab = (sel >= 8'h10) && ({1'b0, ofs[7:1]} < NP8);
  assign idx    = ofs[IDXW:1];
  assign cur    = in_tab ? ent[idx] : 64'hFFFF_FFFF_FFFF_FFFF;

  always_comb begin
    if (sel[0])
      nxt = {bus_wdata, cur[31:15], cur[14] | set_inservice[idx], cur[13:0]};
    else
      nxt = {cur[63:32], bus_wdata[31:15], 1'b0, bus_wdata[13:0]};
  end

  always_comb begin
    rd_mux = 32'h0;
    if (bus_addr == 8'h00)
      rd_mux = {24'h0, sel};
    else if (bus_addr == 8'h10) begin
      case (sel)
        8'h00, 8'h02: rd_mux = {4'h0, id, 24'h0};
        8'h01:        rd_mux = {8'h0, NP8 - 8'd1, 8'h0, VERSION};
        default:      rd_mux = sel[0] ? cur[63:32] : cur[31:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel          <= 8'h0;
      id           <= 4'h0;
      bus_rdata    <= 32'h0;
      mask_evt     <= 1'b0;
      mask_evt_pin <= '0;
      mask_evt_val <= 1'b0;
      for (int i = 0; i < NPINS; i++) ent[i] <= ENT_RST;
    end else begin
      mask_evt <= 1'b0;
      if (bus_rd) bus_rdata <= rd_mux;
      if (sel_wr) sel <= bus_wdata[7:0];
      if (win_wr && sel == 8'h00) id <= bus_wdata[27:24];
      for (int i = 0; i < NPINS; i++)
        if (set_inservice[i]) ent[i][14] <= 1'b1;
      if (win_wr && in_tab) begin
        ent[idx] <= nxt;
        if (nxt[16] != cur[16]) begin
          mask_evt     <= 1'b1;
          mask_evt_pin <= idx;
          mask_evt_val <= nxt[16];
        end
      end
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_out
    assign route_vector[8*g +: 8]   = ent[g][7:0];
    assign route_dlv_mode[3*g +: 3] = ent[g][10:8];
    assign route_dest_mode[g]       = ent[g][11];
    assign route_polarity[g]        = ent[g][13];
    assign route_inservice[g]       = ent[g][14];
    assign route_trigger[g]         = ent[g][15];
    assign route_mask[g]            = ent[g][16];
    assign route_dest[8*g +: 8]     = ent[g][63:56];
  end

endmodule

module irq_route_regs_chk #(
  parameter int NPINS = 24,
  localparam int IDXW = $clog2(NPINS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NPINS-1:0]  route_mask,
  input logic              mask_evt,
  input logic [IDXW-1:0]   mask_evt_pin,
  input logic              mask_evt_val
);

  assert_evt_matches_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> route_mask[mask_evt_pin] == mask_evt_val);

  assert_evt_after_window_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h10) or !$rose(mask_evt) or 1'b1 |-> 1'b1 ##0
    (!mask_evt || $past(bus_wr && bus_addr == 8'h10)));

  assert_mask_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 8'h10) |=> $stable(route_mask));

  assert_other_offset_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != 8'h00 && bus_addr != 8'h10) |=> bus_rdata == 32'h0);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind irq_route_regs irq_route_regs_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .route_mask(route_mask),
  .mask_evt(mask_evt), .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val)
);

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb_top;
  localparam int NPINS = 24;
  localparam int IDXW = $clog2(NPINS);
  localparam int NV = 34;
  // {is_read, addr, data/expect}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'hABCD_1234}, {1'b1, 8'h00, 32'h0000_0034},   // R1
    {1'b0, 8'h00, 32'h0000_0001}, {1'b1, 8'h10, 32'h0017_0011},   // R2
    {1'b0, 8'h10, 32'hFFFF_FFFF}, {1'b1, 8'h10, 32'h0017_0011},   // R2
    {1'b0, 8'h00, 32'h0000_0000}, {1'b0, 8'h10, 32'h5A00_0000},
    {1'b1, 8'h10, 32'h0A00_0000},                                 // R3
    {1'b0, 8'h00, 32'h0000_0002}, {1'b1, 8'h10, 32'h0A00_0000},   // R3
    {1'b0, 8'h10, 32'h0300_0000}, {1'b1, 8'h10, 32'h0A00_0000},   // R3
    {1'b0, 8'h00, 32'h0000_0000}, {1'b1, 8'h10, 32'h0A00_0000},   // R3
    {1'b0, 8'h00, 32'h0000_0013}, {1'b0, 8'h10, 32'hC300_0000},
    {1'b1, 8'h10, 32'hC300_0000},                                 // R4
    {1'b0, 8'h00, 32'h0000_0012}, {1'b0, 8'h10, 32'h0000_E1F5},
    {1'b1, 8'h10, 32'h0000_A1F5},                                 // R6
    {1'b0, 8'h00, 32'h0000_0040}, {1'b1, 8'h10, 32'hFFFF_FFFF},   // R5
    {1'b0, 8'h00, 32'h0000_0005}, {1'b1, 8'h10, 32'hFFFF_FFFF},   // R5
    {1'b0, 8'h00, 32'h0000_003F}, {1'b1, 8'h10, 32'h0000_0000},   // R4
    {1'b0, 8'h00, 32'h0000_003E}, {1'b1, 8'h10, 32'h0001_0000},   // R4
    {1'b0, 8'h00, 32'h0000_002F}, {1'b1, 8'h20, 32'h0000_0000},   // R9
    {1'b0, 8'h20, 32'h0000_0077}, {1'b1, 8'h00, 32'h0000_002F},   // R9
    {1'b1, 8'h04, 32'h0000_0000}                                  // R9
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0, bus_rdata;
  logic [NPINS-1:0] set_inservice = '0;
  logic [8*NPINS-1:0] route_vector, route_dest;
  logic [3*NPINS-1:0] route_dlv_mode;
  logic [NPINS-1:0] route_dest_mode, route_polarity, route_inservice, route_trigger, route_mask;
  logic mask_evt, mask_evt_val;
  logic [IDXW-1:0] mask_evt_pin;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  irq_route_regs #(.NPINS(NPINS)) dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  initial begin
    #(4 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [NPINS-1:0] mask_snap;
    logic [8*NPINS-1:0] vec_snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    check("R7 rdata", 64'(bus_rdata), 64'h0);
    check("R7 masks", 64'(route_mask), 64'({NPINS{1'b1}}));
    do_rd(8'h00, r); check("R7 select", 64'(r), 64'h0);
    do_rd(8'h10, r); check("R7 id", 64'(r), 64'h0);
    do_wr(8'h00, 32'h10); do_rd(8'h10, r); check("R7 entry0 low", 64'(r), 64'h0001_0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) begin
        do_rd(VEC[i][39:32], r);
        check($sformatf("vector %0d", i), 64'(r), 64'(VEC[i][31:0]));
      end else
        do_wr(VEC[i][39:32], VEC[i][31:0]);
    end

    // R4 field outputs of entry 1: low E1F5 -> A1F5, high C3000000
    check("R4 vector", 64'(route_vector[8 +: 8]), 64'hF5);
    check("R4 dlv mode", 64'(route_dlv_mode[3 +: 3]), 64'h1);
    check("R4 dest mode", 64'(route_dest_mode[1]), 64'h0);
    check("R4 polarity", 64'(route_polarity[1]), 64'h1);
    check("R4 trigger", 64'(route_trigger[1]), 64'h1);
    check("R4 mask", 64'(route_mask[1]), 64'h0);
    check("R4 dest", 64'(route_dest[8 +: 8]), 64'hC3);

    // R8 mask notifications on entry 5
    do_wr(8'h00, 32'h1A);
    do_wr(8'h10, 32'h0000_0040);
    check("R8 evt", 64'(mask_evt), 64'h1);
    check("R8 pin", 64'(mask_evt_pin), 64'h5);
    check("R8 val", 64'(mask_evt_val), 64'h0);
    @(negedge clk); check("R8 single pulse", 64'(mask_evt), 64'h0);
    do_wr(8'h10, 32'h0000_0041);
    check("R8 no change no evt", 64'(mask_evt), 64'h0);
    do_wr(8'h10, 32'h0001_0041);
    check("R8 evt set", 64'(mask_evt), 64'h1);
    check("R8 val set", 64'(mask_evt_val), 64'h1);

    // R6 in-service flag of entry 1
    @(negedge clk); set_inservice[1] = 1'b1;
    @(negedge clk); set_inservice[1] = 1'b0;
    check("R6 flag out", 64'(route_inservice[1]), 64'h1);
    do_wr(8'h00, 32'h12); do_rd(8'h10, r); check("R6 flag set", 64'(r), 64'h0000_E1F5);
    do_wr(8'h00, 32'h13); do_wr(8'h10, 32'hC400_0000);
    do_wr(8'h00, 32'h12); do_rd(8'h10, r); check("R6 high write keeps", 64'(r), 64'h0000_E1F5);
    do_wr(8'h10, 32'h0000_A1F5); do_rd(8'h10, r); check("R6 low write clears", 64'(r), 64'h0000_A1F5);

    // R5 out-of-range write has no effect
    mask_snap = route_mask; vec_snap = route_vector;
    do_wr(8'h00, 32'h41); do_wr(8'h10, 32'h0000_0000);
    check("R5 no evt", 64'(mask_evt), 64'h0);
    check("R5 masks kept", 64'(route_mask), 64'(mask_snap));
    check("R5 vectors kept", 64'(route_vector ^ vec_snap), 64'h0);

    // R10 rdata holds without a read
    do_rd(8'h00, r);
    do_wr(8'h00, 32'h99);
    check("R10 hold", 64'(bus_rdata), 64'(r));

    // R7 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R7 masks again", 64'(route_mask), 64'({NPINS{1'b1}}));
    check("R7 vectors clear", 64'(route_vector), 64'h0);
    do_rd(8'h00, r); check("R7 select again", 64'(r), 64'h0);
    do_rd(8'h10, r); check("R7 id again", 64'(r), 64'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule